// File: doc/BRIEF.md
# Parallel Pixel Ramp-Capture Converter

This block is the digital side of an imaging array where every pixel performs its own single-slope conversion. An analog ramp, not part of this block, is shared by all pixels. In step with that ramp, a conversion counter steps once per clock and is sent to every pixel in Gray code. Each pixel's comparator output arrives here as one digital bit. Each pixel has a code register. While its comparator has not yet gone high, the register follows the broadcast count. In the cycle the comparator is first seen high, the register takes that count and then holds it.

All pixels convert in parallel during the same ramp. A ramp lasts one step per code value, so 256 cycles for 8-bit codes. A pixel whose comparator never trips ends with the top code. A readout port selects one pixel and returns its stored value as a plain binary number, with one cycle of latency. A new conversion start at any time sets the counter back to zero and makes every pixel track again.

Top module: `pix_adc_bank`

## Requirements
- R1: After reset the conversion is idle (`conv_busy`=0, `conv_done`=0), `gray_bus` is 0 and every pixel code reads back as 0.
- R2: A cycle with `conv_start`=1 is followed by a cycle with `conv_busy`=1 and `gray_bus`=0, even when a ramp is already running.
- R3: During a ramp, the cycle c after the start (c = 0, 1, …) shows `gray_bus` = c XOR (c >> 1). Successive values therefore differ in exactly one bit.
- R4: A ramp lasts 2^CODE_W cycles (256 by default). After the cycle with count 255, `conv_busy` falls and `conv_done` is 1 for exactly one cycle.
- R5: A pixel whose comparator bit is first high in ramp cycle t stores count t. This includes t=0, which gives code 0. Pixels are independent and all follow the same ramp.
- R6: A pixel whose comparator stays low for the whole ramp stores the final count 255.
- R7: After a pixel has captured, later changes of its comparator bit (falling, or rising again) do not change its stored code before the next start.
- R8: Readout: setting `rd_addr` to a pixel index puts that pixel's count, converted from Gray to binary by a prefix XOR from the MSB down, on `rd_data` one cycle later.
- R9: A start issued in the middle of a ramp discards the captures already made. Every pixel tracks again, and the pixel codes come from the new ramp only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Begin (or restart) a conversion ramp |
| cmp_in | input | NUM_PIX | Per-pixel comparator level, 1 = ramp has crossed the pixel |
| rd_addr | input | ADDR_W | Pixel index to read |
| rd_data | output | CODE_W | Binary code of the selected pixel, registered |
| conv_busy | output | 1 | Ramp in progress |
| conv_done | output | 1 | One-cycle pulse at ramp end |
| gray_bus | output | CODE_W | Broadcast Gray count |

## Verification
Sets of comparator thresholds are applied to all pixels at once. One set leaves every comparator low, which separates the final-code hold from a true capture. One set uses the edge counts 0, 1, 254, 255 and 128, which exposes off-by-one capture timing and bit-order errors in the prefix-XOR decoding. Other sets use scattered and power-of-two thresholds, which show that pixels do not share or swap captures. Some sets drop the comparator back low right after capture, to show that a held code cannot move. A restart in mid-ramp, after captures have been made, shows whether every pixel is re-armed.

// File: rtl/pix_adc_pkg.sv
package pix_adc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RAMP = 1'b1
  } ramp_phase_e;

  function automatic logic [31:0] bin_to_gray32(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // prefix XOR from the MSB down
  function automatic logic [31:0] gray_to_bin32(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/pix_adc_ramp_ctr.sv
module pix_adc_ramp_ctr
  import pix_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] gray_o
);

  localparam logic [CODE_W-1:0] LAST_CNT = {CODE_W{1'b1}};

  ramp_phase_e       phase_q;
  logic [CODE_W-1:0] bin_q;
  logic [CODE_W-1:0] bin_nxt;
  logic [CODE_W-1:0] gray_q;
  logic              done_q;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bin_q   <= '0;
      gray_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        phase_q <= PH_RAMP;
        bin_q   <= '0;
        gray_q  <= '0;
      end else if (phase_q == PH_RAMP) begin
        if (bin_q == LAST_CNT) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end else begin
          bin_q  <= bin_nxt;
          gray_q <= CODE_W'(bin_to_gray32(32'(bin_nxt)));
        end
      end
    end
  end

  assign busy_o = (phase_q == PH_RAMP);
  assign done_o = done_q;
  assign gray_o = gray_q;

  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && gray_o == '0)); // R2

  AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !start_i && bin_q != LAST_CNT) |=>
      ($countones(gray_o ^ $past(gray_o)) == 1)); // R3

  AST_RAMP_END: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !start_i && bin_q == LAST_CNT) |=> (!busy_o && done_o)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4

endmodule

// File: rtl/pix_adc_cell.sv
module pix_adc_cell #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              cmp_i,
  input  logic [CODE_W-1:0] gray_i,
  output logic [CODE_W-1:0] code_o
);

  logic              armed_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      code_q  <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      code_q  <= '0;
    end else if (busy_i && armed_q) begin
      code_q <= gray_i;
      if (cmp_i) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign code_o = code_q;

  AST_CAPTURE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy_i && armed_q && cmp_i && !start_i) |=> (!armed_q && code_q == $past(gray_i))); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !start_i) |=> $stable(code_q)); // R7

  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (armed_q && code_q == '0)); // R9

endmodule

// File: rtl/pix_adc_rdout.sv
module pix_adc_rdout
  import pix_adc_pkg::*;
#(
  parameter int NUM_PIX = 8,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PIX*CODE_W-1:0] codes_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [CODE_W-1:0]         data_o
);

  logic [CODE_W-1:0] sel_gray;
  logic [CODE_W-1:0] data_q;

  always_comb begin
    sel_gray = '0;
    for (int i = 0; i < NUM_PIX; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        sel_gray = codes_i[i*CODE_W +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else begin
      data_q <= CODE_W'(gray_to_bin32(32'(sel_gray)));
    end
  end

  assign data_o = data_q;

  AST_DECODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((data_o ^ (data_o >> 1)) == $past(sel_gray))); // R8

endmodule

// File: rtl/pix_adc_bank.sv
module pix_adc_bank #(
  parameter int NUM_PIX = 8,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               conv_start,
  input  logic [NUM_PIX-1:0] cmp_in,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CODE_W-1:0]  rd_data,
  output logic               conv_busy,
  output logic               conv_done,
  output logic [CODE_W-1:0]  gray_bus
);

  localparam int CODE_BUS_W = NUM_PIX * CODE_W;

  logic                  ramp_busy;
  logic                  ramp_done;
  logic [CODE_W-1:0]     ramp_gray;
  logic [CODE_BUS_W-1:0] pix_codes;

  pix_adc_ramp_ctr #(
    .CODE_W (CODE_W)
  ) ctr_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (conv_start),
    .busy_o  (ramp_busy),
    .done_o  (ramp_done),
    .gray_o  (ramp_gray)
  );

  for (genvar g = 0; g < NUM_PIX; g++) begin : g_pix
    pix_adc_cell #(
      .CODE_W (CODE_W)
    ) cell_i (
      .clk     (clk),
      .rst     (rst),
      .start_i (conv_start),
      .busy_i  (ramp_busy),
      .cmp_i   (cmp_in[g]),
      .gray_i  (ramp_gray),
      .code_o  (pix_codes[g*CODE_W +: CODE_W])
    );
  end

  pix_adc_rdout #(
    .NUM_PIX (NUM_PIX),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W)
  ) rd_i (
    .clk     (clk),
    .rst     (rst),
    .codes_i (pix_codes),
    .addr_i  (rd_addr),
    .data_o  (rd_data)
  );

  assign conv_busy = ramp_busy;
  assign conv_done = ramp_done;
  assign gray_bus  = ramp_gray;

  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && !conv_start) |=> (conv_busy || conv_done)); // R4

endmodule

// File: tb/pix_adc_bank_tb_top.sv
module pix_adc_bank_tb_top;

  localparam int CLK_P = 10;
  localparam int NP    = 8;
  localparam int CW    = 8;
  localparam int NV    = 5;
  localparam int NEVER = 256;

  // thresholds, 9 bits each, pixel 7 first
  localparam logic [NP*9-1:0] THR_TAB [NV] = '{
    {9'd256, 9'd256, 9'd256, 9'd256, 9'd256, 9'd256, 9'd256, 9'd256},
    {9'd128, 9'd256, 9'd255, 9'd254, 9'd3,   9'd2,   9'd1,   9'd0  },
    {9'd80,  9'd70,  9'd60,  9'd50,  9'd40,  9'd30,  9'd20,  9'd10 },
    {9'd100, 9'd64,  9'd32,  9'd16,  9'd8,   9'd4,   9'd2,   9'd1  },
    {9'd0,   9'd3,   9'd5,   9'd7,   9'd50,  9'd99,  9'd150, 9'd200}
  };
  localparam logic PULSE_TAB [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic          clk = 1'b0;
  logic          rst;
  logic          conv_start;
  logic [NP-1:0] cmp_in;
  logic [2:0]    rd_addr;
  logic [CW-1:0] rd_data;
  logic          conv_busy;
  logic          conv_done;
  logic [CW-1:0] gray_bus;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pix_adc_bank dut_i (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .cmp_in     (cmp_in),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .gray_bus   (gray_bus)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ncyc ramp cycles are driven; a full ramp also checks the end pulse
  task automatic do_ramp(input logic [NP*9-1:0] thr, input logic pulse, input int ncyc);
    int gerr;
    gerr = 0;
    @(negedge clk);
    conv_start = 1'b1;
    cmp_in     = '0;
    @(posedge clk);
    @(negedge clk);
    conv_start = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      if (gray_bus != CW'(c ^ (c >> 1)) || !conv_busy) gerr++;
      for (int p = 0; p < NP; p++) begin
        int t;
        t = int'(thr[p*9 +: 9]);
        cmp_in[p] = pulse ? (c == t) : (c >= t);
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R3 gray sequence errors", gerr, 0);
    if (ncyc == 256) begin
      chk("R4 busy after ramp", int'(conv_busy), 0);
      chk("R4 done pulse", int'(conv_done), 1);
      @(posedge clk);
      @(negedge clk);
      chk("R4 done width", int'(conv_done), 0);
    end
  endtask

  task automatic read_pix(input int p, output int val);
    @(negedge clk);
    rd_addr = 3'(p);
    @(posedge clk);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    rst = 1'b1;
    conv_start = 1'b0;
    cmp_in = '0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy at reset", int'(conv_busy), 0);
    chk("R1 done at reset", int'(conv_done), 0);
    chk("R1 gray at reset", int'(gray_bus), 0);
    read_pix(5, v);
    chk("R1 pixel code at reset", v, 0);

    // table walk: R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      do_ramp(THR_TAB[k], PULSE_TAB[k], 256);
      cmp_in = '0;
      for (int p = 0; p < NP; p++) begin
        int t;
        int e;
        t = int'(THR_TAB[k][p*9 +: 9]);
        e = (t >= NEVER) ? 255 : t;
        read_pix(p, v);
        if (t >= NEVER)
          chk("R6 never-tripped pixel", v, e);
        else if (PULSE_TAB[k])
          chk("R7 code held after comparator drop", v, e);
        else
          chk("R5 R8 captured code", v, e);
      end
    end

    // restart mid-ramp: R2 R9
    do_ramp({NP{9'd10}}, 1'b0, 50);
    @(negedge clk);
    conv_start = 1'b1;
    cmp_in = '0;
    @(posedge clk);
    @(negedge clk);
    conv_start = 1'b0;
    chk("R2 gray zero after restart", int'(gray_bus), 0);
    chk("R2 busy after restart", int'(conv_busy), 1);
    for (int c = 0; c < 256; c++) begin
      cmp_in = (c >= 30) ? '1 : '0;
      @(posedge clk);
      @(negedge clk);
    end
    cmp_in = '0;
    for (int p = 0; p < NP; p += 3) begin
      read_pix(p, v);
      chk("R9 code from new ramp", v, 30);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule